// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the transmitting master of an I2C bus once the bus has been claimed. Each write strobe hands it one byte. The byte goes out on SDA, most significant bit first, across eight SCL clocks. A ninth clock follows, and on it the block releases SDA so the receiver can acknowledge. At the end of that ninth clock the block pulls SCL low and keeps it there. It also raises a one-cycle interrupt. The host then either writes the next byte, which ends the wait, or asks for a stop condition.

A stop is built in three steps. First the block pulls SDA low while SCL is still low. It then lets SCL go high. After a programmable setup count it lets SDA go high. The length of each SCL half-period comes from a divider input in system-clock cycles, with a floor of two. Both pins are driven as open-drain enables: a 1 means pull the line low.

A stop request that arrives while a byte is being sent is remembered. The stop then starts at the close of that byte's ninth clock.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_oe, sda_oe, irq, busy and ack_det are all 0.
- R2: An accepted write sends the byte MSB first. For each data bit, sda_oe is the inverse of the bit. A ninth clock follows with sda_oe at 0.
- R3: During a byte, every SCL low phase and every SCL high phase lasts max(div_half, 2) clock cycles.
- R4: While SCL stays released, sda_oe never goes from 0 to 1.
- R5: On the clock edge that releases SCL for the ninth time, ack_det takes the inverse of sda_in. It then holds that value until the next ninth clock.
- R6: The edge that ends the ninth high phase does three things in the same cycle: it sets scl_oe to 1, it sets sda_oe to 0 (unless a stop begins), and it raises irq. irq stays high for exactly one cycle.
- R7: After a byte with no stop pending, SCL is held low with SDA released until wr_stb or stop_req arrives.
- R8: In the stop sequence, sda_oe=1 and scl_oe=1 for max(div_half, 2) cycles. Then SCL is released while SDA stays low for max(stop_setup, 1) cycles. Then SDA is released.
- R9: If stop_req arrives during a byte, it is kept. The stop sequence starts in the cycle irq is raised, with no second request needed.
- R10: If wr_stb and stop_req arrive in the same cycle during the wait, the byte is sent first and the stop follows it automatically.
- R11: wr_stb has no effect while a byte or a stop is in progress. stop_req has no effect while idle.
- R12: busy is 1 from the accepted write until SDA is released at the end of a stop. While busy is 0, both pin enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIV_W | SCL half-period in clk cycles (values below 2 act as 2) |
| stop_setup | input | SU_W | Cycles from SCL release to SDA release in a stop (0 acts as 1) |
| wr_stb | input | 1 | Write strobe that loads wr_byte and starts a byte |
| wr_byte | input | DATA_W | Byte to transmit |
| stop_req | input | 1 | Stop condition request |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ack_det | output | 1 | Acknowledge seen on the last ninth clock |
| irq | output | 1 | One-cycle end-of-byte pulse |
| busy | output | 1 | Transfer or stop in progress |

## Verification
Two pairs of events can land in the same clock cycle.

The first pair is a write strobe and a stop request during the wait. The bench drives both strobes in one cycle. It then checks two things: that the decoded byte is the new one, and that a stop condition follows with no further request.

The second pair is the end-of-byte interrupt and the start of a stop that was requested in mid-byte. The bench checks that in the interrupt cycle both pin enables are already 1. It also measures the stop's low phase and setup phase against the divider and setup inputs.

// File: rtl/i2cbm_pkg.sv
`timescale 1ns/1ps
package i2cbm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_WAIT,
      ST_STOP_LOW,
      ST_STOP_HIGH
   } st_t;

endpackage

// File: rtl/i2cbm_timer.sv
`timescale 1ns/1ps
// Down-counter: once loaded with len, done goes high len cycles later.
module i2cbm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= len - W'(1);
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/i2cbm_shreg.sv
`timescale 1ns/1ps
// Transmit shift register; the parameter picks the bit order.
module i2cbm_shreg #(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] din,
   output logic              bit_o
);

   logic [DATA_W-1:0] sh;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh <= '0;
            else if (load)  sh <= din;
            else if (shift) sh <= {1'b0, sh[DATA_W-1:1]};
         end
         assign bit_o = sh[0];
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh <= '0;
            else if (load)  sh <= din;
            else if (shift) sh <= {sh[DATA_W-2:0], 1'b0};
         end
         assign bit_o = sh[DATA_W-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master
   import i2cbm_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DIV_W     = 8,
   parameter int SU_W      = 8,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_half,
   input  logic [SU_W-1:0]   stop_setup,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              stop_req,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              ack_det,
   output logic              irq,
   output logic              busy
);

   localparam int             TW   = (DIV_W > SU_W) ? DIV_W : SU_W;
   localparam int             BW   = $clog2(DATA_W + 1);
   localparam logic [BW-1:0]  LAST = BW'(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2 to encode the minimum half period");
      end
      if (SU_W < 1) begin : g_bad_su
         $error("SU_W must be at least 1");
      end
   endgenerate

   st_t             st, st_n;
   logic [BW-1:0]   bitidx;
   logic            stop_pend, pend_n;
   logic            irq_n;
   logic            tload, tdone;
   logic [TW-1:0]   tlen, phase_len, setup_len;
   logic            sh_load, sh_shift, sh_bit;
   logic            idx_clr, idx_inc, ack_smp;

   // Half-period floor of two cycles, setup floor of one.
   assign phase_len = (div_half < DIV_W'(2)) ? TW'(2) : TW'(div_half);
   assign setup_len = (stop_setup == '0) ? TW'(1) : TW'(stop_setup);

   i2cbm_timer #(.W(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tload),
      .len   (tlen),
      .done  (tdone)
   );

   i2cbm_shreg #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sh_load),
      .shift (sh_shift),
      .din   (wr_byte),
      .bit_o (sh_bit)
   );

   always_comb begin
      st_n     = st;
      pend_n   = stop_pend;
      irq_n    = 1'b0;
      tload    = 1'b0;
      tlen     = phase_len;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      idx_clr  = 1'b0;
      idx_inc  = 1'b0;
      ack_smp  = 1'b0;
      case (st)
         ST_IDLE: begin
            if (wr_stb) begin
               st_n    = ST_LOW;
               tload   = 1'b1;
               sh_load = 1'b1;
               idx_clr = 1'b1;
               pend_n  = 1'b0;
            end
         end
         ST_LOW: begin
            if (stop_req) pend_n = 1'b1;
            if (tdone) begin
               st_n    = ST_HIGH;
               tload   = 1'b1;
               ack_smp = (bitidx == LAST);
            end
         end
         ST_HIGH: begin
            if (stop_req) pend_n = 1'b1;
            if (tdone) begin
               tload = 1'b1;
               if (bitidx == LAST) begin
                  irq_n = 1'b1;
                  if (stop_pend || stop_req) begin
                     st_n   = ST_STOP_LOW;
                     pend_n = 1'b0;
                  end else begin
                     st_n = ST_WAIT;
                  end
               end else begin
                  st_n     = ST_LOW;
                  sh_shift = 1'b1;
                  idx_inc  = 1'b1;
               end
            end
         end
         ST_WAIT: begin
            if (wr_stb) begin
               st_n    = ST_LOW;
               tload   = 1'b1;
               sh_load = 1'b1;
               idx_clr = 1'b1;
               pend_n  = stop_req;
            end else if (stop_req) begin
               st_n  = ST_STOP_LOW;
               tload = 1'b1;
            end
         end
         ST_STOP_LOW: begin
            if (tdone) begin
               st_n  = ST_STOP_HIGH;
               tload = 1'b1;
               tlen  = setup_len;
            end
         end
         ST_STOP_HIGH: begin
            if (tdone) st_n = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bitidx    <= '0;
         stop_pend <= 1'b0;
         ack_det   <= 1'b0;
         irq       <= 1'b0;
      end else begin
         st        <= st_n;
         stop_pend <= pend_n;
         irq       <= irq_n;
         if (idx_clr)      bitidx <= '0;
         else if (idx_inc) bitidx <= bitidx + BW'(1);
         if (ack_smp)      ack_det <= ~sda_in;
      end
   end

   always_comb begin
      case (st)
         ST_LOW, ST_HIGH:           sda_oe = (bitidx != LAST) ? ~sh_bit : 1'b0;
         ST_STOP_LOW, ST_STOP_HIGH: sda_oe = 1'b1;
         default:                   sda_oe = 1'b0;
      endcase
   end

   assign scl_oe = (st == ST_LOW) || (st == ST_WAIT) || (st == ST_STOP_LOW);
   assign busy   = (st != ST_IDLE);

endmodule

// File: rtl/i2cbm_chk.sv
`timescale 1ns/1ps
module i2cbm_chk
   import i2cbm_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic stop_req,
   input logic scl_oe,
   input logic sda_oe,
   input logic irq,
   input logic busy,
   input logic stop_pend,
   input st_t  st
);

   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> scl_oe);

   p_high_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_oe) |=> !scl_oe);

   p_low_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_oe) && busy) |=> scl_oe);

   p_no_sda_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe)) |-> !(sda_oe && !$past(sda_oe)));

   p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !wr_stb && !stop_req) |=> (st == ST_WAIT));

   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && wr_stb && stop_req) |=> (st == ST_LOW && stop_pend));

   p_idle_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !wr_stb) |=> (st == ST_IDLE));

   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!sda_oe && !scl_oe && $past(sda_oe) && !$past(scl_oe)));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

endmodule

bind i2c_byte_master i2cbm_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb    (wr_stb),
   .stop_req  (stop_req),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .irq       (irq),
   .busy      (busy),
   .stop_pend (stop_pend),
   .st        (st)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_half = 8'd3;
   logic [7:0] stop_setup = 8'd1;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_byte = 8'd0;
   logic       stop_req = 1'b0;
   logic       sda_in;
   logic       scl_oe, sda_oe, ack_det, irq, busy;

   always #4 clk = ~clk;

   // fields: [31:28] stop after, [27:24] ack from slave, [23:16] setup, [15:8] div, [7:0] byte
   localparam logic [31:0] VEC [6] = '{
      32'h01_04_03_A5,
      32'h00_02_05_3C,
      32'h11_06_02_FF,
      32'h01_00_01_00,
      32'h10_00_00_81,
      32'h11_09_07_5A
   };

   int   nchk = 0, nfail = 0;
   logic ack_cfg = 1'b0;
   int   rises = 0, run_len = 0, ph_err = 0, sda_err = 0;
   int   ll_run = 0, ll_last = 0, hl_run = 0;
   int   stop_cnt = 0, stop_ll = 0, stop_hl = 0;
   int   exp_half = 3, exp_su = 1;
   logic [7:0] cap = 8'd0;
   logic ninth_rel = 1'b0;
   logic prev_scl = 1'b0, prev_sda = 1'b0, mon_on = 1'b0;
   logic ack_drive;

   assign ack_drive = ack_cfg && ((rises == 8 && scl_oe) || (rises == 9 && !scl_oe));
   assign sda_in = !(sda_oe || ack_drive);

   i2c_byte_master uut (
      .clk(clk), .rst_n(rst_n), .div_half(div_half), .stop_setup(stop_setup),
      .wr_stb(wr_stb), .wr_byte(wr_byte), .stop_req(stop_req), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .ack_det(ack_det), .irq(irq), .busy(busy)
   );

   // Bus monitor working only on the pin enables
   always @(negedge clk) begin
      if (mon_on) begin
         if (scl_oe != prev_scl) begin
            if (!scl_oe) begin
               rises = rises + 1;
               if (rises >= 2 && rises <= 9 && run_len != exp_half) ph_err++;
               if (rises <= 8) cap = {cap[6:0], !sda_oe};
               if (rises == 9) ninth_rel = !sda_oe;
            end else begin
               if (rises >= 1 && rises <= 9 && run_len != exp_half) ph_err++;
            end
            run_len = 1;
         end else begin
            run_len = run_len + 1;
         end
         if (!scl_oe && !prev_scl && sda_oe && !prev_sda) sda_err++;
         if (scl_oe && sda_oe) ll_run++;
         else begin
            if (ll_run != 0) ll_last = ll_run;
            ll_run = 0;
         end
         if (!scl_oe && sda_oe) hl_run++;
         else begin
            if (!scl_oe && !prev_scl && prev_sda && !sda_oe) begin
               stop_cnt++;
               stop_ll = ll_last;
               stop_hl = hl_run;
            end
            hl_run = 0;
         end
         prev_scl = scl_oe;
         prev_sda = sda_oe;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic start_byte(input logic [7:0] b, input logic with_stop);
      rises = 0; cap = 8'd0; ph_err = 0; ninth_rel = 1'b0;
      wr_byte = b; wr_stb = 1'b1; stop_req = with_stop;
      tick();
      wr_stb = 1'b0; stop_req = 1'b0;
   endtask

   task automatic wait_irq(output bit got);
      got = 1'b0;
      for (int k = 0; k < 5000 && !got; k++) begin
         tick();
         if (irq) got = 1'b1;
      end
   endtask

   task automatic wait_idle(output bit got);
      got = 1'b0;
      for (int k = 0; k < 5000 && !got; k++) begin
         tick();
         if (!busy) got = 1'b1;
      end
   endtask

   function automatic int floor_at(input int v, input int lo);
      return (v < lo) ? lo : v;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      bit got;
      int sc;
      logic [31:0] v;
      tick(); tick();
      // R1 reset state
      chk(!scl_oe && !sda_oe && !irq && !busy && !ack_det, "R1", "reset outputs",
          {scl_oe, sda_oe, irq, busy, ack_det}, 0);
      rst_n = 1'b1;
      tick();
      mon_on = 1'b1;
      tick();

      for (int i = 0; i < 6; i++) begin
         v          = VEC[i];
         div_half   = v[15:8];
         stop_setup = v[23:16];
         ack_cfg    = v[24];
         exp_half   = floor_at(int'(v[15:8]), 2);
         exp_su     = floor_at(int'(v[23:16]), 1);
         start_byte(v[7:0], 1'b0);
         chk(busy, "R12", "busy after write", busy, 1);
         wait_irq(got);
         chk(got, "R6", "irq raised", got, 1);
         chk(scl_oe && !sda_oe, "R6", "pins at irq", {scl_oe, sda_oe}, 2);
         chk(cap == v[7:0], "R2", "decoded byte", cap, v[7:0]);
         chk(ninth_rel, "R2", "sda released on ninth clock", ninth_rel, 1);
         chk(ph_err == 0, "R3", "half-period errors", ph_err, 0);
         chk(ack_det == v[24], "R5", "ack flag", ack_det, v[24]);
         chk(sda_err == 0, "R4", "sda fall while scl high", sda_err, 0);
         tick();
         chk(!irq, "R6", "irq one cycle", irq, 0);
         repeat (3 * exp_half) tick();
         chk(scl_oe && !sda_oe && busy, "R7", "wait hold", {scl_oe, sda_oe, busy}, 5);
         if (v[28]) begin
            sc = stop_cnt;
            stop_req = 1'b1;
            tick();
            stop_req = 1'b0;
            wait_idle(got);
            chk(got && stop_cnt == sc + 1, "R8", "stop seen", stop_cnt, sc + 1);
            chk(stop_ll == exp_half, "R8", "stop low phase", stop_ll, exp_half);
            chk(stop_hl == exp_su, "R8", "stop setup", stop_hl, exp_su);
            chk(!scl_oe && !sda_oe && !busy, "R12", "idle after stop", {scl_oe, sda_oe, busy}, 0);
         end
      end

      // R11: stop request while idle has no effect
      div_half = 8'd4; stop_setup = 8'd2; exp_half = 4; exp_su = 2; ack_cfg = 1'b1;
      sc = stop_cnt;
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      repeat (4) tick();
      chk(!busy && !scl_oe && !sda_oe && stop_cnt == sc, "R11", "stop in idle ignored",
          {busy, scl_oe, sda_oe}, 0);

      // R11: write strobe during a byte has no effect
      start_byte(8'hA5, 1'b0);
      repeat (10) tick();
      wr_byte = 8'h00; wr_stb = 1'b1; tick(); wr_stb = 1'b0;
      wait_irq(got);
      chk(got && cap == 8'hA5, "R11", "write in flight ignored", cap, 8'hA5);

      // R10: write and stop in the same wait cycle
      sc = stop_cnt;
      start_byte(8'h3C, 1'b1);
      wait_irq(got);
      chk(got && cap == 8'h3C, "R10", "byte sent before stop", cap, 8'h3C);
      chk(scl_oe && sda_oe, "R10", "stop starts after byte", {scl_oe, sda_oe}, 3);
      wait_idle(got);
      chk(got && stop_cnt == sc + 1, "R10", "automatic stop", stop_cnt, sc + 1);

      // R9: stop requested in mid-byte starts with irq
      sc = stop_cnt;
      start_byte(8'hC3, 1'b0);
      repeat (12) tick();
      stop_req = 1'b1; tick(); stop_req = 1'b0;
      wait_irq(got);
      chk(got && scl_oe && sda_oe, "R9", "stop low at irq", {scl_oe, sda_oe}, 3);
      chk(cap == 8'hC3, "R9", "byte intact", cap, 8'hC3);
      wait_idle(got);
      chk(got && stop_cnt == sc + 1, "R9", "pending stop done", stop_cnt, sc + 1);
      chk(stop_ll == exp_half && stop_hl == exp_su, "R8", "pending stop timing",
          stop_ll * 256 + stop_hl, exp_half * 256 + exp_su);

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule